// File: doc/BRIEF.md
# Interrupt Priority Level Resolver

This block turns a set of pending interrupt sources into one priority level and decides whether that level is high enough to interrupt the running code. Software requests and external lines arrive as separate bit vectors. Each source range has its own bit-to-level mapping. A software bit gives a level counted from the bottom of the software range. An external bit gives a level equal to its own bit index. When any external line is pending, the external level always replaces the software level.

Evaluation is armed by a one-cycle check strobe and runs on the next cycle that is not blocked. Privileged mode blocks evaluation, and so does the cycle that resumes after an instruction-fetch miss. An evaluation clears the armed state whether or not it takes an interrupt. A request is taken when the resolved level is nonzero and strictly above the current priority level. On a take, the block raises a one-cycle trap pulse and captures the summary mask and the level. A nonzero asynchronous-trap request seen during an evaluation is unsupported; it sets a sticky error flag.

Top module: `irq_level_resolver`

## Requirements
- R1: While reset is high and on the first cycle after it falls, trap_o, summary_o, int_id_o and async_err_o are all zero.
- R2: A software bit i with 1 <= i <= 15 maps to level i - 1 + 1. The highest set software bit in that range decides the software level. Software bit 0 and software bits 16..31 are ignored.
- R3: An external bit i with 16 <= i <= 31 maps to level i. The highest such bit decides. Whenever any external bit is pending, its level replaces the software level. External bits 0..15 are ignored.
- R4: The summary mask is the OR of the software bits in 1..15 and the external bits in 16..31, each placed at its own bit position.
- R5: An evaluation takes the interrupt only when the resolved level is nonzero and strictly greater than cur_ipl_i. An equal level is not taken.
- R6: On a take, trap_o is high for exactly one cycle, and summary_o and int_id_o load the summary mask and the level. Without a take, summary_o and int_id_o keep their values.
- R7: While priv_mode_i is high, no evaluation happens and the armed state is kept. The evaluation then runs on the first cycle after priv_mode_i falls.
- R8: While fetch_resume_i is high, no evaluation happens and the armed state is kept. The evaluation then runs on the first cycle after fetch_resume_i falls.
- R9: Every evaluation clears the armed state, whether or not it takes. No further trap occurs until chk_arm_i is pulsed again, even if cur_ipl_i later drops.
- R10: A nonzero async_req_i during an evaluation sets async_err_o. The flag stays high until reset.
- R11: A chk_arm_i pulse at edge k arms evaluation. That evaluation happens at edge k+1 if it is not blocked, and trap_o is visible right after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sw_req_i | input | 32 | Pending software interrupt requests |
| ext_req_i | input | 32 | Pending external interrupt lines |
| cur_ipl_i | input | 5 | Current interrupt priority level |
| priv_mode_i | input | 1 | Privileged mode; blocks evaluation |
| fetch_resume_i | input | 1 | Resume cycle after fetch miss; blocks evaluation |
| chk_arm_i | input | 1 | Strobe that arms one evaluation |
| async_req_i | input | 4 | Asynchronous-trap request (unsupported when nonzero) |
| trap_o | output | 1 | One-cycle interrupt trap pulse |
| summary_o | output | 32 | Captured interrupt summary mask |
| int_id_o | output | 5 | Captured interrupt level |
| async_err_o | output | 1 | Sticky unsupported-request error |

## Verification
The bench builds the block with its default parameters: a 32-bit vector, software range 1..15, external range 16..31 and 5-bit levels. With these values every level from 1 to 31 is reachable, and the software-to-external boundary at bit 15/16 can be driven directly. The bench also drives out-of-range bits in both vectors, and sets the current level equal to, just below and just above the resolved level, so that the strict comparison and the masking are exposed.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

  // Level of bit idx inside a range starting at lo.
  // direct=1: level equals the bit index; direct=0: offset from lo, plus one.
  function automatic int map_level(input int idx, input int lo, input bit direct);
    if (direct) return idx;
    return idx - lo + 1;
  endfunction

  // Strict priority comparison used by the take decision.
  function automatic bit level_wins(input int lvl, input int cur);
    return (lvl != 0) && (lvl > cur);
  endfunction

endpackage

// File: rtl/irq_range_scan.sv
module irq_range_scan #(
  parameter int  VEC_W  = 32,
  parameter int  LVL_W  = 5,
  parameter int  LO     = 1,
  parameter int  HI     = 15,
  parameter bit  DIRECT = 1'b0
) (
  input  logic [VEC_W-1:0] req_i,
  output logic [VEC_W-1:0] mask_o,
  output logic [LVL_W-1:0] lvl_o
);
  import irq_res_pkg::*;

  function automatic logic [VEC_W-1:0] build_range_mask();
    logic [VEC_W-1:0] m;
    m = '0;
    for (int i = 0; i < VEC_W; i++) begin
      if (i >= LO && i <= HI) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [VEC_W-1:0] RANGE_MASK = build_range_mask();

  assign mask_o = req_i & RANGE_MASK;

  // Ascending scan: later (higher) set bits overwrite earlier ones.
  always_comb begin
    lvl_o = '0;
    for (int i = LO; i <= HI; i++) begin
      if (mask_o[i]) lvl_o = LVL_W'(map_level(i, LO, DIRECT));
    end
  end

endmodule

// File: rtl/irq_take_ctl.sv
module irq_take_ctl #(
  parameter int VEC_W = 32,
  parameter int LVL_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             arm_i,
  input  logic             priv_i,
  input  logic             resume_i,
  input  logic             async_nz_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [LVL_W-1:0] cur_i,
  input  logic [VEC_W-1:0] summary_i,
  output logic             eval_o,
  output logic             take_o,
  output logic             pend_o,
  output logic             trap_o,
  output logic [VEC_W-1:0] summary_o,
  output logic [LVL_W-1:0] id_o,
  output logic             err_o
);
  import irq_res_pkg::*;

  logic pend_q;

  assign pend_o = pend_q;
  assign eval_o = pend_q & ~priv_i & ~resume_i;
  assign take_o = eval_o & level_wins(int'(lvl_i), int'(cur_i));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q    <= 1'b0;
      trap_o    <= 1'b0;
      summary_o <= '0;
      id_o      <= '0;
      err_o     <= 1'b0;
    end else begin
      if (arm_i)       pend_q <= 1'b1;
      else if (eval_o) pend_q <= 1'b0;
      trap_o <= take_o;
      if (take_o) begin
        summary_o <= summary_i;
        id_o      <= lvl_i;
      end
      if (eval_o && async_nz_i) err_o <= 1'b1;
    end
  end

  // R10: the error flag never falls outside reset
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o);

  // R9: an evaluation without a new strobe leaves nothing armed
  assert_eval_clears_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (eval_o && !arm_i) |=> !pend_q);

  // R11: a trap always follows an armed cycle
  assert_trap_needs_arm_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    trap_o |-> $past(pend_q));

  // R6: captured id matches the level presented when the trap was decided
  assert_id_capture_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    trap_o |-> (id_o == $past(lvl_i)));

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int VEC_W   = 32,
  parameter int LVL_W   = 5,
  parameter int ASYNC_W = 4,
  parameter int SW_LO   = 1,
  parameter int SW_HI   = 15,
  parameter int EXT_LO  = 16,
  parameter int EXT_HI  = 31
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [VEC_W-1:0]   sw_req_i,
  input  logic [VEC_W-1:0]   ext_req_i,
  input  logic [LVL_W-1:0]   cur_ipl_i,
  input  logic               priv_mode_i,
  input  logic               fetch_resume_i,
  input  logic               chk_arm_i,
  input  logic [ASYNC_W-1:0] async_req_i,
  output logic               trap_o,
  output logic [VEC_W-1:0]   summary_o,
  output logic [LVL_W-1:0]   int_id_o,
  output logic               async_err_o
);

  logic [VEC_W-1:0] sw_mask, ext_mask, summary_w;
  logic [LVL_W-1:0] sw_lvl, ext_lvl, merged_lvl;
  logic             eval_w, take_w, pend_w;

  irq_range_scan #(.VEC_W(VEC_W), .LVL_W(LVL_W), .LO(SW_LO), .HI(SW_HI), .DIRECT(1'b0))
    u_sw_scan (.req_i(sw_req_i), .mask_o(sw_mask), .lvl_o(sw_lvl));

  irq_range_scan #(.VEC_W(VEC_W), .LVL_W(LVL_W), .LO(EXT_LO), .HI(EXT_HI), .DIRECT(1'b1))
    u_ext_scan (.req_i(ext_req_i), .mask_o(ext_mask), .lvl_o(ext_lvl));

  // External sources override software ones
  assign merged_lvl = (ext_lvl != '0) ? ext_lvl : sw_lvl;
  assign summary_w  = sw_mask | ext_mask;

  irq_take_ctl #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_ctl (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .arm_i     (chk_arm_i),
    .priv_i    (priv_mode_i),
    .resume_i  (fetch_resume_i),
    .async_nz_i(|async_req_i),
    .lvl_i     (merged_lvl),
    .cur_i     (cur_ipl_i),
    .summary_i (summary_w),
    .eval_o    (eval_w),
    .take_o    (take_w),
    .pend_o    (pend_w),
    .trap_o    (trap_o),
    .summary_o (summary_o),
    .id_o      (int_id_o),
    .err_o     (async_err_o)
  );

  // R5: a taken level is nonzero and strictly above the priority level at decision time
  assert_take_strict_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    trap_o |-> (int_id_o != '0 && int_id_o > $past(cur_ipl_i)));

  // R7: privileged mode suppresses any trap decided in that cycle
  assert_priv_blocks_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(priv_mode_i) |-> !trap_o);

  // R8: fetch-resume cycle suppresses any trap decided in that cycle
  assert_resume_blocks_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(fetch_resume_i) |-> !trap_o);

  // R3: any pending external line yields a level inside the external range
  assert_ext_override_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (|ext_mask) |-> (int'(merged_lvl) >= EXT_LO));

  // R6: a take is a single pulse unless re-armed
  assert_trap_pulse_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (take_w && !chk_arm_i) |=> !pend_w);

  // R11: an armed, unblocked cycle always evaluates
  assert_arm_eval_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(chk_arm_i) && !priv_mode_i && !fetch_resume_i) |-> eval_w);

endmodule

// File: tb/irq_level_resolver_tb.sv
`timescale 1ns/1ps
module irq_level_resolver_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] sw_req, ext_req;
  logic [4:0]  cur_ipl;
  logic        priv, resume, arm;
  logic [3:0]  async_req;
  logic        trap;
  logic [31:0] summary;
  logic [4:0]  int_id;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_sum;
  logic [4:0]  exp_id;
  logic        exp_err;

  always #10 clk = ~clk;

  irq_level_resolver dut_i (
    .clk_i(clk), .rst_i(rst), .sw_req_i(sw_req), .ext_req_i(ext_req),
    .cur_ipl_i(cur_ipl), .priv_mode_i(priv), .fetch_resume_i(resume),
    .chk_arm_i(arm), .async_req_i(async_req), .trap_o(trap),
    .summary_o(summary), .int_id_o(int_id), .async_err_o(err));

  // Expected level: external wins via a downward search; otherwise software.
  function automatic logic [4:0] ref_level(input logic [31:0] s, input logic [31:0] e);
    for (int i = 31; i >= 16; i--) if (e[i]) return 5'(i);
    for (int i = 15; i >= 1; i--)  if (s[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic logic [31:0] ref_summary(input logic [31:0] s, input logic [31:0] e);
    return (s & 32'h0000_FFFE) | (e & 32'hFFFF_0000);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input logic exp_trap, input string req);
    check(trap == exp_trap, {req, " trap"}, 32'(trap), 32'(exp_trap));
    check(summary == exp_sum, {req, " summary R4"}, summary, exp_sum);
    check(int_id == exp_id, {req, " id R2/R3"}, 32'(int_id), 32'(exp_id));
    check(err == exp_err, {req, " err R10"}, 32'(err), 32'(exp_err));
  endtask

  // Predict one unblocked evaluation
  function automatic logic predict(input logic [31:0] s, input logic [31:0] e,
                                   input logic [4:0] c, input logic [3:0] a);
    logic [4:0] l;
    l = ref_level(s, e);
    if (a != 4'd0) exp_err = 1'b1;
    if (l != 5'd0 && l > c) begin
      exp_sum = ref_summary(s, e);
      exp_id  = l;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic run_case(input logic [31:0] s, input logic [31:0] e, input logic [4:0] c,
                          input logic [3:0] a, input logic p, input logic r, input string tag);
    logic t;
    @(negedge clk);
    sw_req = s; ext_req = e; cur_ipl = c; async_req = a; priv = p; resume = r; arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
    if (p || r) begin
      // R7 / R8: blocked, nothing happens yet
      check_outputs(1'b0, {tag, " blocked R7/R8"});
      priv = 1'b0; resume = 1'b0;
      @(negedge clk);
    end
    t = predict(s, e, c, a);
    check_outputs(t, {tag, " eval R5/R6/R11"});
    @(negedge clk);
    // R6 pulse width, R9 disarm
    check(trap == 1'b0, {tag, " pulse R6/R9"}, 32'(trap), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, e;
    logic [4:0]  c;
    logic [3:0]  a;
    logic        p, r;
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    rst = 1'b1; sw_req = '0; ext_req = '0; cur_ipl = '0; priv = 1'b0;
    resume = 1'b0; arm = 1'b0; async_req = '0;
    exp_sum = '0; exp_id = '0; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    check_outputs(1'b0, "reset R1");
    rst = 1'b0;
    @(negedge clk);
    check_outputs(1'b0, "after reset R1");

    // R2: software only, highest bit wins, bit 0 ignored
    run_case(32'h0000_0029, 32'h0, 5'd0, 4'd0, 1'b0, 1'b0, "sw mix R2");
    check(int_id == 5'd5, "R2 level of bit5", 32'(int_id), 32'd5);
    run_case(32'h0000_0001, 32'h0, 5'd0, 4'd0, 1'b0, 1'b0, "sw bit0 ignored R2");
    run_case(32'hFFFF_8000, 32'h0, 5'd3, 4'd0, 1'b0, 1'b0, "sw top R2");
    check(int_id == 5'd15, "R2 top sw level", 32'(int_id), 32'd15);
    // R3: external overrides, low external bits ignored
    run_case(32'h0000_8000, 32'h0001_0000, 5'd0, 4'd0, 1'b0, 1'b0, "ext override R3");
    check(int_id == 5'd16, "R3 ext level", 32'(int_id), 32'd16);
    run_case(32'h0, 32'h0000_FFFF, 5'd0, 4'd0, 1'b0, 1'b0, "ext low ignored R3");
    run_case(32'h0000_0004, 32'h8000_0100, 5'd30, 4'd0, 1'b0, 1'b0, "ext 31 R3/R4");
    // R5: equal not taken, one below taken
    run_case(32'h0000_0080, 32'h0, 5'd7, 4'd0, 1'b0, 1'b0, "equal R5");
    check(trap == 1'b0, "R5 equal no trap", 32'(trap), 32'd0);
    run_case(32'h0000_0080, 32'h0, 5'd6, 4'd0, 1'b0, 1'b0, "below R5");
    // R7 / R8 deferred evaluation
    run_case(32'h0000_0200, 32'h0, 5'd1, 4'd0, 1'b1, 1'b0, "priv R7");
    run_case(32'h0, 32'h0040_0000, 5'd1, 4'd0, 1'b0, 1'b1, "resume R8");
    // R9: disarm after a non-taken evaluation, then lower level with no strobe
    run_case(32'h0000_0010, 32'h0, 5'd20, 4'd0, 1'b0, 1'b0, "no take R9");
    @(negedge clk);
    cur_ipl = 5'd0;
    repeat (3) @(negedge clk);
    check(trap == 1'b0, "R9 no retrigger", 32'(trap), 32'd0);
    check(summary == exp_sum, "R9 summary unchanged R6", summary, exp_sum);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      s = $urandom();
      e = ($urandom_range(0, 1) == 0) ? 32'h0 : ($urandom() & $urandom());
      c = 5'($urandom_range(0, 31));
      a = ($urandom_range(0, 15) == 0) ? 4'($urandom_range(1, 15)) : 4'd0;
      p = ($urandom_range(0, 7) == 0);
      r = ($urandom_range(0, 7) == 0);
      run_case(s, e, c, a, p, r, "random");
    end

    // R10: error stays after more evaluations
    run_case(32'h0000_0002, 32'h0, 5'd0, 4'd9, 1'b0, 1'b0, "async R10");
    run_case(32'h0000_0002, 32'h0, 5'd0, 4'd0, 1'b0, 1'b0, "async sticky R10");
    check(err == 1'b1, "R10 sticky", 32'(err), 32'd1);

    // R1: reset clears everything again
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_sum = '0; exp_id = '0; exp_err = 1'b0;
    @(negedge clk);
    check_outputs(1'b0, "re-reset R1");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule